// File: doc/BRIEF.md
# Mode-Shadowed Register File

This block holds the sixteen 32-bit general registers of a processor core and the saved-status copies that go with its privilege modes. Several register numbers resolve to different physical storage depending on the active mode. The stack pointer (register 13), the link register (register 14) and the saved status word each have a private copy in every exception mode. The fast-interrupt mode also has its own registers 8 to 12. All other modes share a single set of those five registers.

The core presents a 5-bit mode code and a one-cycle change strobe. The new mode takes effect at the next clock edge. There are two combinational read ports and one write port. A separate port reads and writes the saved status word of the active mode. Reads always resolve through the mode held in the register file. A write that arrives together with a mode change is steered through the incoming mode, so an exception entry can deposit its return address in the same cycle it switches mode.

Top module: `mode_regfile`

## Requirements
- R1: After reset every register copy and every saved status copy reads zero, and `cur_mode` reads 5'h1F (system).
- R2: Mode codes map to storage sets as follows: 5'h10 user and 5'h1F system select the common set; 5'h11 fast interrupt, 5'h12 interrupt, 5'h13 supervisor, 5'h17 abort and 5'h1B undefined each select their own set. Any other code selects the common set.
- R3: Modes on the common set share registers 13 and 14. They have no saved status word: `spsr_rdata` reads zero and `spsr_we` is ignored.
- R4: Each exception mode has its own registers 13 and 14 and its own saved status word. Each copy keeps its value while other modes are active.
- R5: Registers 8 to 12 have a private copy only in fast-interrupt mode. Every other mode, valid or not, sees one shared copy.
- R6: Registers 0 to 7 and register 15 are the same storage in every mode.
- R7: When `mode_chg` is high, a register write or a saved-status write in that cycle goes to the copy that belongs to `mode_req`.
- R8: When `mode_chg` is high, `cur_mode` takes `mode_req` at the next edge. Without the strobe the mode holds. Requesting the active mode changes nothing.
- R9: Read ports are combinational on the stored state. A write becomes visible on the cycle after it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 5 | Requested mode code |
| mode_chg | input | 1 | Apply `mode_req` at the next edge |
| ra_idx | input | 4 | Read port A register number |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B register number |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| spsr_we | input | 1 | Saved status write enable |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_rdata | output | 32 | Saved status word of the active mode |
| cur_mode | output | 5 | Active mode code |

## Verification
A mode change and a register write, a saved-status write, or both can fall in the same cycle. The write must then land in the copy of the incoming mode. The bench provokes this by raising `mode_chg`, `wr_en` and `spsr_we` together at random, including entries to and exits from fast-interrupt mode while registers 8 to 14 are targeted. A behavioural reference copies registers in and out of a visible set on every switch, applies the write after that swap, and is compared on both read ports and the status port every cycle. Directed steps also cover the case where an active mode is requested again and the case of an unknown code.

// File: rtl/mode_regfile.sv
module mode_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode_req,
  input  logic          mode_chg,
  input  logic [3:0]    ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          spsr_we,
  input  logic [DW-1:0] spsr_wdata,
  output logic [DW-1:0] spsr_rdata,
  output logic [4:0]    cur_mode
);
  localparam int NREG = 16;
  localparam int NFQ  = 7;
  localparam int NEXC = 4;

  logic [DW-1:0] com [NREG];
  logic [DW-1:0] fq  [NFQ];
  logic [DW-1:0] exc [NEXC][2];
  logic [DW-1:0] sps [NEXC+1];
  logic [4:0]    mode_q;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'h11:   return 3'd1;
      5'h12:   return 3'd2;
      5'h13:   return 3'd3;
      5'h17:   return 3'd4;
      5'h1B:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  logic [2:0] cur_bank, nxt_bank;
  assign cur_bank = bank_of(mode_q);
  assign nxt_bank = bank_of(mode_chg ? mode_req : mode_q);
  assign cur_mode = mode_q;

  function automatic logic [DW-1:0] pick(input logic [3:0] i, input logic [2:0] b,
                                         input logic [DW-1:0] c, input logic [DW-1:0] f,
                                         input logic [DW-1:0] e);
    if (b == 3'd1 && i >= 4'd8 && i <= 4'd14) return f;
    if (b >= 3'd2 && i >= 4'd13 && i <= 4'd14) return e;
    return c;
  endfunction

  always_comb begin
    ra_data = pick(ra_idx, cur_bank, com[ra_idx],
                   fq[(ra_idx >= 4'd8 && ra_idx <= 4'd14) ? ra_idx - 4'd8 : 4'd0],
                   exc[(cur_bank >= 3'd2) ? cur_bank - 3'd2 : 3'd0][ra_idx[0] ? 1'b0 : 1'b1]);
    rb_data = pick(rb_idx, cur_bank, com[rb_idx],
                   fq[(rb_idx >= 4'd8 && rb_idx <= 4'd14) ? rb_idx - 4'd8 : 4'd0],
                   exc[(cur_bank >= 3'd2) ? cur_bank - 3'd2 : 3'd0][rb_idx[0] ? 1'b0 : 1'b1]);
    spsr_rdata = (cur_bank == 3'd0) ? '0 : sps[cur_bank - 3'd1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 5'h1F;
      for (int i = 0; i < NREG; i++) com[i] <= '0;
      for (int i = 0; i < NFQ; i++) fq[i] <= '0;
      for (int i = 0; i < NEXC; i++) begin
        exc[i][0] <= '0;
        exc[i][1] <= '0;
      end
      for (int i = 0; i <= NEXC; i++) sps[i] <= '0;
    end else begin
      if (mode_chg) mode_q <= mode_req;
      if (wr_en) begin
        if (nxt_bank == 3'd1 && wr_idx >= 4'd8 && wr_idx <= 4'd14)
          fq[wr_idx - 4'd8] <= wr_data;
        else if (nxt_bank >= 3'd2 && wr_idx >= 4'd13 && wr_idx <= 4'd14)
          exc[nxt_bank - 3'd2][wr_idx[0] ? 1'b0 : 1'b1] <= wr_data;
        else
          com[wr_idx] <= wr_data;
      end
      if (spsr_we && nxt_bank != 3'd0) sps[nxt_bank - 3'd1] <= spsr_wdata;
    end
  end

  p_mode_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> cur_mode == $past(mode_req));
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |=> $stable(cur_mode));
  p_no_spsr_common_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 5'h10 || cur_mode == 5'h1F) |-> spsr_rdata == '0);
  p_pc_unbanked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'hF) |=> (ra_idx != 4'hF || ra_data == $past(wr_data)));
endmodule

// File: tb/mode_regfile_tb_top.sv
module mode_regfile_tb_top;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [4:0] mode_req = 5'h1F, cur_mode;
  logic mode_chg = 0, wr_en = 0, spsr_we = 0;
  logic [3:0] ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic [31:0] ra_data, rb_data, wr_data = 0, spsr_wdata = 0, spsr_rdata;

  mode_regfile dut_i (.clk, .rst_n, .mode_req, .mode_chg, .ra_idx, .ra_data,
    .rb_idx, .rb_data, .wr_en, .wr_idx, .wr_data, .spsr_we, .spsr_wdata,
    .spsr_rdata, .cur_mode);

  int checks = 0, errors = 0;
  logic [31:0] vis [16];
  logic [31:0] bsp [6], blr [6], bps [6], hi [2][5];
  logic [31:0] vps;
  logic [4:0]  mmode;

  function automatic int bk(input logic [4:0] m);
    if (m == 5'h11) return 1;
    if (m == 5'h12) return 2;
    if (m == 5'h13) return 3;
    if (m == 5'h17) return 4;
    if (m == 5'h1B) return 5;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) vis[i] = 0;
      for (int i = 0; i < 6; i++) begin bsp[i] = 0; blr[i] = 0; bps[i] = 0; end
      for (int i = 0; i < 5; i++) begin hi[0][i] = 0; hi[1][i] = 0; end
      vps = 0; mmode = 5'h1F;
    end else begin
      if (mode_chg && mode_req != mmode) begin
        int ob, nb;
        ob = bk(mmode); nb = bk(mode_req);
        if (ob != nb) begin
          if (ob == 1 || nb == 1) begin
            for (int i = 0; i < 5; i++) hi[ob == 1][i] = vis[8+i];
            for (int i = 0; i < 5; i++) vis[8+i] = hi[nb == 1][i];
          end
          bsp[ob] = vis[13]; blr[ob] = vis[14]; bps[ob] = vps;
          vis[13] = bsp[nb]; vis[14] = blr[nb]; vps = bps[nb];
        end
        mmode = mode_req;
      end
      if (wr_en) vis[wr_idx] = wr_data;
      if (spsr_we && bk(mmode) != 0) vps = spsr_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] i);
    if (i < 8 || i == 15) return "R6";
    if (i <= 12) return "R5";
    return (bk(mmode) == 0) ? "R3" : "R4";
  endfunction

  task automatic compare();
    chk(tag_of(ra_idx), ra_data, vis[ra_idx]);
    chk(tag_of(rb_idx), rb_data, vis[rb_idx]);
    chk((bk(mmode) == 0) ? "R3 spsr" : "R4 spsr", spsr_rdata, vps);
    chk("R8 mode", {27'd0, cur_mode}, {27'd0, mmode});
  endtask

  task automatic step(input logic c, input logic [4:0] m, input logic w, input logic [3:0] wi,
                      input logic [31:0] wd, input logic sw, input logic [31:0] sd);
    @(negedge clk);
    mode_chg = c; mode_req = m; wr_en = w; wr_idx = wi; wr_data = wd;
    spsr_we = sw; spsr_wdata = sd;
    ra_idx = 4'($urandom); rb_idx = 4'($urandom);
    #1 compare();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] ml [8];
    ml = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h05};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 16; i++) begin
      ra_idx = 4'(i); rb_idx = 4'(15 - i); #0.1;
      chk("R1 reset", ra_data, 32'd0);
    end
    chk("R1 mode", {27'd0, cur_mode}, 32'h1F);
    chk("R1 spsr", spsr_rdata, 32'd0);
    // R7: enter fast interrupt while writing r9 and the saved status word
    step(1, 5'h11, 1, 4'd9, 32'hAAAA0009, 1, 32'h5A5A);
    step(0, 5'h11, 0, 0, 0, 0, 0);
    ra_idx = 4'd9; #0.1; chk("R7 write new bank", ra_data, 32'hAAAA0009);
    chk("R7 spsr new bank", spsr_rdata, 32'h5A5A);
    // R8: requesting the active mode changes nothing
    step(1, 5'h11, 0, 0, 0, 0, 0);
    step(0, 5'h11, 0, 0, 0, 0, 0);
    ra_idx = 4'd9; #0.1; chk("R8 same mode", ra_data, 32'hAAAA0009);
    // R2: unknown code uses the common set, r9 shared copy is zero
    step(1, 5'h05, 0, 0, 0, 1, 32'h1234);
    step(0, 5'h05, 0, 0, 0, 0, 0);
    ra_idx = 4'd9; #0.1; chk("R2 unknown code", ra_data, 32'd0);
    chk("R2 unknown spsr", spsr_rdata, 32'd0);
    // R9: write not visible in the issuing cycle
    step(0, 5'h05, 1, 4'd3, 32'hCAFE, 0, 0);
    ra_idx = 4'd3; #0.1; chk("R9 before edge", ra_data, 32'd0);
    step(0, 5'h05, 0, 0, 0, 0, 0);
    ra_idx = 4'd3; #0.1; chk("R9 after edge", ra_data, 32'hCAFE);
    for (int n = 0; n < 4000; n++)
      step(($urandom % 4) == 0, ml[$urandom % 8], $urandom % 2, 4'($urandom),
           $urandom, ($urandom % 3) == 0, $urandom);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule